// File: doc/BRIEF.md
# Atomic Multi-Byte Register Access Unit

This unit sits between an 8-bit register bus and a register that is wider than one byte, such as a timer count or a stack pointer. The bus sees the wide register as a run of byte addresses, with byte 0 holding the least significant bits. The unit makes those byte-wise accesses behave as one access to the whole register.

Reading byte 0 returns the live low byte. In the same edge, the unit copies every higher byte of the live value into a snapshot store. Later reads of the higher bytes come from that snapshot, so software sees one coherent value even if the register kept changing between reads. Writes to bytes below the top byte only fill a staging store. Writing the top byte presents the full new value, built from that byte and the staged bytes, to the underlying register with a one-cycle write enable.

When the unit guards a stack pointer, a write to byte 0 raises an interrupt-inhibit output for a fixed number of cycles, so that the top byte can follow before any interrupt uses a half-updated pointer. The bus port has no back-pressure: a strobe is accepted on the edge where it is seen. Read data appears on the cycle after the read strobe and holds until the next read. No valid/ready handshake is used, because the bus never stalls.

Top module: `atom_mbreg`

## Requirements
- R1: A read strobe at byte address 0 loads `bus_rdata` at that clock edge with bits [7:0] of `reg_q`. The value is visible in the following cycle. `bus_rdata` changes only on edges with a read strobe.
- R2: A read at address 0 captures bits [W-1:8] of `reg_q` into the snapshot at the same edge. A later read at address k (1 ≤ k < NBYTES) returns snapshot byte k-1, that is the value live at the byte-0 read, whatever `reg_q` has become since.
- R3: The snapshot changes only on a byte-0 read. A higher-byte read with no byte-0 read since reset returns 0.
- R4: A write at address k < NBYTES-1 stores `bus_wdata` into staging byte k. It does not assert `reg_we`, and it leaves the other staged bytes unchanged.
- R5: A write at address NBYTES-1 asserts `reg_we` in that same cycle, combinationally from the strobe. `reg_d` equals `bus_wdata` in the top byte and the staged bytes below it. At all other times `reg_we` is 0.
- R6: With SP_MODE=1, the edge that takes a write at address 0 raises `irq_inhibit` for exactly INH_CYCLES (default 4) following cycles. It then falls.
- R7: A further byte-0 write while `irq_inhibit` is high restarts the count from INH_CYCLES.
- R8: After reset, `bus_rdata`, the snapshot, the staging bytes and `irq_inhibit` are all 0.
- R9: An address of NBYTES or higher reads as 0 and leaves the snapshot alone. A write to such an address changes no staged byte and does not assert `reg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the wide register |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, registered |
| reg_q | input | NBYTES*8 | Live value of the wide register |
| reg_d | output | NBYTES*8 | Full value to commit |
| reg_we | output | 1 | Commit enable for the wide register |
| irq_inhibit | output | 1 | Interrupt-inhibit window (SP_MODE only) |

## Verification
The assertions check several behaviours on every cycle. Byte-0 reads capture the live low byte and load the snapshot. The snapshot and staging stores hold their values between the accesses that own them. The inhibit counter loads to the full window on a byte-0 write and counts down one step per cycle otherwise. Only the bench scenarios can show the end-to-end coherence of a multi-byte read while the register changes underneath it, the exact commit value after a sweep of staged bytes, the restart of the inhibit window, and the silence of out-of-range addresses.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/atom_rdpath.sv
module atom_rdpath
  import atom_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic [NBYTES*BYTE_W-1:0] reg_q,
  output byte_t                    bus_rdata
);
  localparam int W  = NBYTES * BYTE_W;
  localparam int SW = W - BYTE_W;

  logic [SW-1:0] shadow_q;
  byte_t         rdata_q;
  byte_t         rd_next;
  logic          rd_low;

  assign rd_low = bus_rd && (bus_addr == '0);

  always_comb begin
    rd_next = '0;
    if (bus_addr == '0) begin
      rd_next = reg_q[BYTE_W-1:0];
    end else begin
      for (int k = 1; k < NBYTES; k++) begin
        if (bus_addr == ADDR_W'(k)) rd_next = shadow_q[(k-1)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (bus_rd) rdata_q <= rd_next;
      if (rd_low) shadow_q <= reg_q[W-1:BYTE_W];
    end
  end

  assign bus_rdata = rdata_q;

  AST_RD_LOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low |=> bus_rdata == $past(reg_q[BYTE_W-1:0])); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R1
  AST_SNAPSHOT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low |=> shadow_q == $past(reg_q[W-1:BYTE_W])); // R2
  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_low |=> $stable(shadow_q)); // R3
endmodule

// File: rtl/atom_wrpath.sv
module atom_wrpath
  import atom_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  byte_t                    bus_wdata,
  output logic [NBYTES*BYTE_W-1:0] reg_d,
  output logic                     reg_we
);
  localparam int W  = NBYTES * BYTE_W;
  localparam int SW = W - BYTE_W;
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NBYTES - 1);

  logic [SW-1:0] stage_q;
  logic          wr_stage;

  assign wr_stage = bus_wr && (bus_addr < TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int k = 0; k < NBYTES - 1; k++) begin
        if (bus_wr && bus_addr == ADDR_W'(k)) stage_q[k*BYTE_W +: BYTE_W] <= bus_wdata;
      end
    end
  end

  assign reg_we = bus_wr && (bus_addr == TOP);
  assign reg_d  = {bus_wdata, stage_q};

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stage |=> $stable(stage_q)); // R4
  AST_STAGE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |-> !reg_we); // R4
  AST_COMMIT_LOW_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && $past(!wr_stage)) |-> reg_d[SW-1:0] == $past(reg_d[SW-1:0])); // R5
endmodule

// File: rtl/atom_inhibit.sv
module atom_inhibit #(
  parameter int INH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic inhibit
);
  localparam int CW = $clog2(INH_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (arm)          cnt_q <= CW'(INH_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign inhibit = (cnt_q != '0);

  AST_INH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> cnt_q == CW'(INH_CYCLES)); // R7
  AST_INH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1)); // R6
  AST_INH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && cnt_q == '0) |=> !inhibit); // R6
endmodule

// File: rtl/atom_mbreg.sv
module atom_mbreg
  import atom_pkg::*;
#(
  parameter int NBYTES     = 4,
  parameter int ADDR_W     = 3,
  parameter bit SP_MODE    = 1'b1,
  parameter int INH_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [NBYTES*8-1:0]      reg_q,
  output logic [NBYTES*8-1:0]      reg_d,
  output logic                     reg_we,
  output logic                     irq_inhibit
);
  localparam int W = NBYTES * BYTE_W;

  atom_rdpath #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .reg_q(reg_q), .bus_rdata(bus_rdata)
  );

  atom_wrpath #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .reg_d(reg_d), .reg_we(reg_we)
  );

  generate
    if (SP_MODE) begin : g_sp
      atom_inhibit #(.INH_CYCLES(INH_CYCLES)) u_inh (
        .clk(clk), .rst_n(rst_n),
        .arm(bus_wr && bus_addr == '0),
        .inhibit(irq_inhibit)
      );
    end else begin : g_plain
      assign irq_inhibit = 1'b0;
    end
  endgenerate

  initial begin
    if (NBYTES < 2 || NBYTES > 4) $error("NBYTES must be 2..4");
    if ((1 << ADDR_W) < NBYTES) $error("ADDR_W too small");
  end

  AST_WE_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (bus_wr && bus_addr == ADDR_W'(NBYTES - 1))); // R5
  AST_TOP_BYTE_IS_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_d[W-1:W-BYTE_W] == bus_wdata); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (bus_rdata == '0 && !irq_inhibit)); // R8
endmodule

// File: tb/atom_mbreg_bench.sv
`timescale 1ns/1ps
module atom_mbreg_bench;
  localparam int NB = 3;
  localparam int AW = 2;
  localparam int W  = NB * 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [W-1:0] reg_d;
  logic reg_we, irq_inhibit;
  logic [W-1:0] reg_mdl;
  logic ext_set = 0;
  logic [W-1:0] ext_val = '0;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n)       reg_mdl <= '0;
    else if (reg_we)  reg_mdl <= reg_d;
    else if (ext_set) reg_mdl <= ext_val;
  end

  atom_mbreg #(.NBYTES(NB), .ADDR_W(AW), .SP_MODE(1'b1), .INH_CYCLES(4)) u_atom_mbreg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_q(reg_mdl), .reg_d(reg_d),
    .reg_we(reg_we), .irq_inhibit(irq_inhibit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_reg(input logic [W-1:0] v);
    @(negedge clk); ext_val = v; ext_set = 1;
    @(negedge clk); ext_set = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v,
                    output logic we, output logic [W-1:0] dv);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    #1 we = reg_we; dv = reg_d;
    @(negedge clk); bus_wr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic we;
    logic [W-1:0] dv;
    logic [W-1:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 rdata", bus_rdata, 0);
    chk("R8 inhibit", irq_inhibit, 0);
    chk("R8 we", reg_we, 0);
    // R3 higher bytes without a low read return zero shadow
    rd(2'd1, d); chk("R3 stale byte1", d, 0);
    rd(2'd2, d); chk("R3 stale byte2", d, 0);

    // R1 R2 coherent read sweep
    for (int i = 0; i < 64; i++) begin
      v  = W'(i * 32'h0A5C3 + 32'h1F2E3D);
      v2 = v ^ W'(32'hFFFFFF) ^ W'(i);
      set_reg(v);
      rd(2'd0, d); chk("R1 low byte", d, v[7:0]);
      set_reg(v2);
      rd(2'd1, d); chk("R2 snap byte1", d, v[15:8]);
      rd(2'd2, d); chk("R2 snap byte2", d, v[23:16]);
      rd(2'd2, d); chk("R3 snap repeat", d, v[23:16]);
    end
    // R1 rdata holds without read strobe
    @(negedge clk); @(negedge clk);
    chk("R1 rdata hold", bus_rdata, v[23:16]);

    // R9 out-of-range read
    rd(2'd3, d); chk("R9 oob read", d, 0);

    // R4 R5 staged writes and commit
    for (int i = 0; i < 48; i++) begin
      logic [7:0] b0, b1, b2;
      b0 = 8'(i * 37 + 5); b1 = 8'(i * 91 + 200); b2 = 8'(255 - i * 3);
      v = reg_mdl;
      wr(2'd0, b0, we, dv); chk("R4 no commit b0", we, 0);
      wr(2'd1, b1, we, dv); chk("R4 no commit b1", we, 0);
      chk("R4 reg unchanged", reg_mdl, v);
      if (i % 4 == 0) begin
        wr(2'd3, 8'hEE, we, dv); chk("R9 oob write no commit", we, 0);
      end
      wr(2'd2, b2, we, dv);
      chk("R5 commit we", we, 1);
      chk("R5 commit value", dv, {b2, b1, b0});
      chk("R5 reg updated", reg_mdl, {b2, b1, b0});
      @(negedge clk);
      chk("R5 we drops", reg_we, 0);
    end
    // R4 restaging one byte keeps the other
    wr(2'd1, 8'h3C, we, dv);
    wr(2'd2, 8'h81, we, dv);
    chk("R4 partial restage", dv[15:0], {8'h3C, 8'(47 * 37 + 5)});

    // R6 inhibit window after low-byte write
    repeat (6) @(negedge clk);
    chk("R6 idle", irq_inhibit, 0);
    wr(2'd0, 8'h10, we, dv);
    for (int c = 0; c < 4; c++) begin
      chk("R6 window", irq_inhibit, 1);
      @(negedge clk);
    end
    chk("R6 window end", irq_inhibit, 0);
    // R6 top-byte write does not arm
    wr(2'd2, 8'h20, we, dv);
    chk("R6 top no arm", irq_inhibit, 0);

    // R7 restart
    wr(2'd0, 8'h11, we, dv);
    @(negedge clk);
    wr(2'd0, 8'h12, we, dv);
    for (int c = 0; c < 4; c++) begin
      chk("R7 restarted window", irq_inhibit, 1);
      @(negedge clk);
    end
    chk("R7 window end", irq_inhibit, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule